// File: doc/BRIEF.md
# Writeback Frame Capture Controller

This block is the control and status engine of a display writeback path. Software programs a destination address, a line pitch and the frame dimensions over a 32-bit register bus, then sets a start bit. The engine latches that configuration and hands one raster line start address at a time to a memory write port. It counts each line that the port reports as committed, and it returns to idle once the last line of the frame is committed.

When idle after a completed frame, the engine can raise a level interrupt. Software can halt a frame at any point with an abort bit, which stops further line requests at once. A power-down bit keeps the engine from accepting any frame. The destination address is 40 bits wide and is split between a low-pointer register and a high-pointer register. A build parameter selects whether the dimension fields hold the size itself or the size minus one.

Top module: `wbcap_ctrl`

## Requirements
- R1: After reset, the engine is idle, `irq` and `line_valid` are 0, progress (offset 0x10) reads 0, and the control register (offset 0x0C) reads 0x5440_0000.
- R2: Control bits 31:24 always read 0x54 and bits 23:22 always read 01. The start bit (bit 0) and the abort bit (bit 14) always read 0.
- R3: Low pointer (0x00) bits 1:0 and pitch (0x04) bits 3:0 read back as 0 whatever was written. High pointer (0x14) keeps only bits 7:0. Dimension (0x08) reads back as written.
- R4: Writing control with bit 0 set, while idle and with power-down clear, starts a frame. Control bit 1 (busy) reads 1 and `line_valid` is 1 from the next clock cycle.
- R5: The start address of line n is {high[7:0], low[31:0]} + n × pitch, carried across the full 40 bits. Pointer and pitch are latched at start, so later writes do not affect the running frame.
- R6: Width is taken from dimension bits 15:0 and height from bits 31:16. With DIM_MINUS_ONE=1 (the default) the frame has height+1 lines and `line_width` is width+1. With DIM_MINUS_ONE=0 a field value of 0 is treated as 1.
- R7: The progress register counts `line_done` pulses received while a line is awaiting commit. It is cleared at frame start and holds its value after the frame ends.
- R8: When the last line is committed, busy drops to 0 and a done flag sets. `irq` equals done AND control bit 2. A control write with bit 2 = 0 clears the done flag, so `irq` stays 0 even if bit 2 is set again later.
- R9: A start request while busy is ignored: line addresses continue and progress is not cleared.
- R10: A control write with bit 14 set while busy makes busy and `line_valid` 0 on the next cycle. It does not raise `irq` and leaves progress unchanged.
- R11: While control bit 21 (power-down) is set, a start request is ignored. Once bit 21 is cleared, a start request works again.
- R12: `line_done` or `line_ready` pulses that arrive while no line is outstanding do not change progress or start a line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| irq | output | 1 | Level interrupt: frame done and interrupt enabled |
| line_valid | output | 1 | A line start address is offered to the write port |
| line_ready | input | 1 | Write port accepts the offered line |
| line_addr | output | 40 | Start address of the offered line |
| line_width | output | 17 | Effective line width in pixels |
| line_done | input | 1 | Last beat of the accepted line has been acknowledged |

## Verification
The bench uses a starting address just below a 4 GiB boundary, so line addresses must carry into the high byte. A design that adds only 32 bits would wrap line 1 back into the same 4 GiB region. It rewrites the pointer in mid-frame and issues a second start while busy. A design that does not latch its configuration, or that does not gate the start bit on busy, would change the next line address or clear progress. It aborts a frame while a line is outstanding and then sends a late commit. It checks that busy falls, that no interrupt appears and that the count is frozen, which a design that keeps counting stray acknowledgements would fail. It also clears and then re-enables the interrupt bit, and issues a start under power-down, which catches a sticky interrupt and a powered-down engine that still accepts frames.

// File: rtl/wbcap_pkg.sv
package wbcap_pkg;
  localparam int DATA_W = 32;
  localparam int OFS_W  = 5;
  localparam int ADDR_W = 40;
  localparam int HI_W   = ADDR_W - DATA_W;
  localparam int DIM_W  = 16;
  localparam int CNT_W  = DIM_W + 1;

  localparam logic [OFS_W-1:0] OFS_PTR_LO = 5'h00;
  localparam logic [OFS_W-1:0] OFS_PITCH  = 5'h04;
  localparam logic [OFS_W-1:0] OFS_DIM    = 5'h08;
  localparam logic [OFS_W-1:0] OFS_CTRL   = 5'h0C;
  localparam logic [OFS_W-1:0] OFS_PROG   = 5'h10;
  localparam logic [OFS_W-1:0] OFS_PTR_HI = 5'h14;

  localparam int BIT_GO    = 0;
  localparam int BIT_BUSY  = 1;
  localparam int BIT_IRQEN = 2;
  localparam int BIT_STOP  = 14;
  localparam int BIT_PDOWN = 21;

  localparam logic [7:0] ID_MARK = 8'h54;
  localparam logic [1:0] ID_REV  = 2'b01;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_ISSUE, SEQ_WAIT} seq_state_t;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [DATA_W-1:0] pitch;
    logic [DIM_W-1:0]  width;
    logic [DIM_W-1:0]  height;
  } frame_cfg_t;
endpackage

// File: rtl/wbcap_regs.sv
module wbcap_regs
  import wbcap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [OFS_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              busy_i,
  input  logic              frame_done_i,
  input  logic [CNT_W-1:0]  progress_i,
  output logic              start_o,
  output logic              abort_o,
  output frame_cfg_t        cfg_o,
  output logic              irq_o
);
  localparam logic [DATA_W-1:0] PTR_MASK   = ~DATA_W'(3);
  localparam logic [DATA_W-1:0] PITCH_MASK = ~DATA_W'(15);

  logic [DATA_W-1:0] ptr_lo_q, ptr_lo_d;
  logic [HI_W-1:0]   ptr_hi_q, ptr_hi_d;
  logic [DATA_W-1:0] pitch_q,  pitch_d;
  logic [DATA_W-1:0] dim_q,    dim_d;
  logic              irqen_q,  irqen_d;
  logic              pdown_q,  pdown_d;
  logic              done_q,   done_d;
  logic              wr_ctrl;

  assign wr_ctrl = reg_we && (reg_addr == OFS_CTRL);
  assign abort_o = wr_ctrl && reg_wdata[BIT_STOP];
  assign start_o = wr_ctrl && reg_wdata[BIT_GO] && !reg_wdata[BIT_STOP] &&
                   !busy_i && !pdown_q && !reg_wdata[BIT_PDOWN];

  always_comb begin
    ptr_lo_d = ptr_lo_q;
    ptr_hi_d = ptr_hi_q;
    pitch_d  = pitch_q;
    dim_d    = dim_q;
    irqen_d  = irqen_q;
    pdown_d  = pdown_q;
    done_d   = done_q;
    if (reg_we) begin
      case (reg_addr)
        OFS_PTR_LO: ptr_lo_d = reg_wdata & PTR_MASK;
        OFS_PTR_HI: ptr_hi_d = reg_wdata[HI_W-1:0];
        OFS_PITCH:  pitch_d  = reg_wdata & PITCH_MASK;
        OFS_DIM:    dim_d    = reg_wdata;
        OFS_CTRL: begin
          irqen_d = reg_wdata[BIT_IRQEN];
          pdown_d = reg_wdata[BIT_PDOWN];
        end
        default: ;
      endcase
    end
    if (start_o)
      done_d = 1'b0;
    else if (frame_done_i)
      done_d = 1'b1;
    else if (wr_ctrl && !reg_wdata[BIT_IRQEN])
      done_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_lo_q <= '0;
      ptr_hi_q <= '0;
      pitch_q  <= '0;
      dim_q    <= '0;
      irqen_q  <= 1'b0;
      pdown_q  <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      ptr_lo_q <= ptr_lo_d;
      ptr_hi_q <= ptr_hi_d;
      pitch_q  <= pitch_d;
      dim_q    <= dim_d;
      irqen_q  <= irqen_d;
      pdown_q  <= pdown_d;
      done_q   <= done_d;
    end
  end

  assign cfg_o.base   = {ptr_hi_q, ptr_lo_q};
  assign cfg_o.pitch  = pitch_q;
  assign cfg_o.width  = dim_q[DIM_W-1:0];
  assign cfg_o.height = dim_q[2*DIM_W-1:DIM_W];
  assign irq_o        = done_q && irqen_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_PTR_LO: reg_rdata = ptr_lo_q;
      OFS_PTR_HI: reg_rdata = DATA_W'(ptr_hi_q);
      OFS_PITCH:  reg_rdata = pitch_q;
      OFS_DIM:    reg_rdata = dim_q;
      OFS_PROG:   reg_rdata = DATA_W'(progress_i);
      OFS_CTRL: begin
        reg_rdata[31:24]     = ID_MARK;
        reg_rdata[23:22]     = ID_REV;
        reg_rdata[BIT_PDOWN] = pdown_q;
        reg_rdata[BIT_IRQEN] = irqen_q;
        reg_rdata[BIT_BUSY]  = busy_i;
      end
      default: reg_rdata = '0;
    endcase
  end

  // R8
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> !busy_i);

  // R11
  pdown_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pdown_q && !busy_i) |=> !busy_i);
endmodule

// File: rtl/wbcap_seq.sv
module wbcap_seq
  import wbcap_pkg::*;
#(
  parameter bit DIM_MINUS_ONE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              abort_i,
  input  frame_cfg_t        cfg_i,
  input  logic              line_ready_i,
  input  logic              line_done_i,
  output logic              busy_o,
  output logic              frame_done_o,
  output logic [CNT_W-1:0]  progress_o,
  output logic              line_valid_o,
  output logic [ADDR_W-1:0] line_addr_o,
  output logic [CNT_W-1:0]  line_width_o
);
  seq_state_t        state_q, state_d;
  logic [ADDR_W-1:0] addr_q,  addr_d;
  logic [DATA_W-1:0] pitch_q, pitch_d;
  logic [CNT_W-1:0]  total_q, total_d;
  logic [CNT_W-1:0]  width_q, width_d;
  logic [CNT_W-1:0]  prog_q,  prog_d;
  logic [CNT_W-1:0]  prog_inc;
  logic              done_evt;

  function automatic logic [CNT_W-1:0] eff_size(input logic [DIM_W-1:0] v);
    if (DIM_MINUS_ONE)
      return CNT_W'(v) + CNT_W'(1);
    else
      return (v == '0) ? CNT_W'(1) : CNT_W'(v);
  endfunction

  assign prog_inc = prog_q + CNT_W'(1);

  always_comb begin
    state_d  = state_q;
    addr_d   = addr_q;
    pitch_d  = pitch_q;
    total_d  = total_q;
    width_d  = width_q;
    prog_d   = prog_q;
    done_evt = 1'b0;
    case (state_q)
      SEQ_IDLE: if (start_i) begin
        state_d = SEQ_ISSUE;
        addr_d  = cfg_i.base;
        pitch_d = cfg_i.pitch;
        total_d = eff_size(cfg_i.height);
        width_d = eff_size(cfg_i.width);
        prog_d  = '0;
      end
      SEQ_ISSUE: if (line_ready_i) begin
        addr_d  = addr_q + ADDR_W'(pitch_q);
        state_d = SEQ_WAIT;
      end
      SEQ_WAIT: if (line_done_i) begin
        prog_d = prog_inc;
        if (prog_inc == total_q) begin
          state_d  = SEQ_IDLE;
          done_evt = 1'b1;
        end else begin
          state_d = SEQ_ISSUE;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
    if (abort_i && (state_q != SEQ_IDLE)) begin
      state_d  = SEQ_IDLE;
      addr_d   = addr_q;
      prog_d   = prog_q;
      done_evt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      addr_q  <= '0;
      pitch_q <= '0;
      total_q <= '0;
      width_q <= '0;
      prog_q  <= '0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      pitch_q <= pitch_d;
      total_q <= total_d;
      width_q <= width_d;
      prog_q  <= prog_d;
    end
  end

  assign busy_o       = (state_q != SEQ_IDLE);
  assign line_valid_o = (state_q == SEQ_ISSUE);
  assign line_addr_o  = addr_q;
  assign line_width_o = width_q;
  assign progress_o   = prog_q;
  assign frame_done_o = done_evt;

  // R9
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> (state_q == SEQ_IDLE));

  // R10
  abort_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_i && busy_o) |=> (!busy_o && !line_valid_o));

  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_valid_o && line_ready_i && !abort_i) |=>
      (line_addr_o == $past(line_addr_o) + ADDR_W'($past(pitch_q))));

  // R7
  progress_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (prog_q < total_q));

  // R12
  progress_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q != SEQ_WAIT) && !start_i) |=> $stable(prog_q));
endmodule

// File: rtl/wbcap_ctrl.sv
module wbcap_ctrl
  import wbcap_pkg::*;
#(
  parameter bit DIM_MINUS_ONE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [OFS_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  output logic              line_valid,
  input  logic              line_ready,
  output logic [ADDR_W-1:0] line_addr,
  output logic [CNT_W-1:0]  line_width,
  input  logic              line_done
);
  logic [1:0]       rst_sync_q;
  logic             rst_n_int;
  logic             start_w, abort_w, busy_w, done_w;
  logic [CNT_W-1:0] prog_w;
  frame_cfg_t       cfg_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  wbcap_regs regs_i (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .reg_we       (reg_we),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .busy_i       (busy_w),
    .frame_done_i (done_w),
    .progress_i   (prog_w),
    .start_o      (start_w),
    .abort_o      (abort_w),
    .cfg_o        (cfg_w),
    .irq_o        (irq)
  );

  wbcap_seq #(.DIM_MINUS_ONE(DIM_MINUS_ONE)) seq_i (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .start_i      (start_w),
    .abort_i      (abort_w),
    .cfg_i        (cfg_w),
    .line_ready_i (line_ready),
    .line_done_i  (line_done),
    .busy_o       (busy_w),
    .frame_done_o (done_w),
    .progress_o   (prog_w),
    .line_valid_o (line_valid),
    .line_addr_o  (line_addr),
    .line_width_o (line_width)
  );
endmodule

// File: tb/wbcap_ctrl_tb_top.sv
module wbcap_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [4:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq, line_valid, line_ready, line_done;
  logic [39:0] line_addr;
  logic [16:0] line_width;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  wbcap_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .line_valid(line_valid), .line_ready(line_ready), .line_addr(line_addr),
    .line_width(line_width), .line_done(line_done)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse_done();
    line_done = 1'b1;
    @(posedge clk); @(negedge clk);
    line_done = 1'b0;
  endtask

  task automatic serve_line(input logic [39:0] exp, input string req);
    chk({req, " line_valid"}, 64'(line_valid), 64'd1);
    chk({req, " line_addr"}, 64'(line_addr), 64'(exp));
    line_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    line_ready = 1'b0;
    pulse_done();
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq", 64'(irq), 64'd0);
    chk("R1 line_valid", 64'(line_valid), 64'd0);
    rd(5'h10, d); chk("R1 progress", 64'(d), 64'd0);
    rd(5'h0C, d); chk("R1 ctrl", 64'(d), 64'h5440_0000);
  endtask

  task automatic t_fields();
    logic [31:0] d;
    wr(5'h00, 32'hFFFF_FF03); rd(5'h00, d); chk("R3 ptr_lo", 64'(d), 64'hFFFF_FF00);
    wr(5'h04, 32'h0000_010F); rd(5'h04, d); chk("R3 pitch", 64'(d), 64'h100);
    wr(5'h14, 32'h0000_0112); rd(5'h14, d); chk("R3 ptr_hi", 64'(d), 64'h12);
    wr(5'h08, 32'h0002_013F); rd(5'h08, d); chk("R3 dim", 64'(d), 64'h0002_013F);
    wr(5'h0C, 32'h0000_4000); rd(5'h0C, d); chk("R2 ctrl id", 64'(d), 64'h5440_0000);
  endtask

  task automatic t_frame();
    logic [31:0] d;
    wr(5'h0C, 32'h5);
    rd(5'h0C, d); chk("R4 busy", 64'(d), 64'h5440_0006);
    chk("R6 line_width", 64'(line_width), 64'h140);
    serve_line(40'h12_FFFF_FF00, "R5 line0");
    rd(5'h10, d); chk("R7 progress 1", 64'(d), 64'd1);
    wr(5'h00, 32'h0000_0000);
    serve_line(40'h13_0000_0000, "R5 line1 carry");
    chk("R8 irq mid-frame", 64'(irq), 64'd0);
    serve_line(40'h13_0000_0100, "R6 line2 last");
    rd(5'h0C, d); chk("R8 idle", 64'(d), 64'h5440_0004);
    chk("R8 irq", 64'(irq), 64'd1);
    rd(5'h10, d); chk("R7 progress held", 64'(d), 64'd3);
  endtask

  task automatic t_irq_clear();
    wr(5'h0C, 32'h0); chk("R8 irq cleared", 64'(irq), 64'd0);
    wr(5'h0C, 32'h4); chk("R8 irq stays clear", 64'(irq), 64'd0);
  endtask

  task automatic t_idle_pulses();
    logic [31:0] d;
    line_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    line_ready = 1'b0;
    pulse_done();
    rd(5'h10, d); chk("R12 progress idle", 64'(d), 64'd3);
    chk("R12 no line", 64'(line_valid), 64'd0);
  endtask

  task automatic t_busy_go();
    logic [31:0] d;
    wr(5'h14, 32'h0); wr(5'h00, 32'h2000); wr(5'h04, 32'h40);
    wr(5'h08, 32'h0003_0007);
    wr(5'h0C, 32'h5);
    rd(5'h10, d); chk("R7 progress cleared", 64'(d), 64'd0);
    serve_line(40'h2000, "R9 line0");
    wr(5'h00, 32'h9000);
    wr(5'h0C, 32'h5);
    rd(5'h10, d); chk("R9 progress kept", 64'(d), 64'd1);
    serve_line(40'h2040, "R9 line1");
    serve_line(40'h2080, "R9 line2");
    serve_line(40'h20C0, "R6 line3");
    chk("R8 irq frame2", 64'(irq), 64'd1);
  endtask

  task automatic t_abort();
    logic [31:0] d;
    wr(5'h0C, 32'h5);
    chk("R8 irq cleared by start", 64'(irq), 64'd0);
    serve_line(40'h9000, "R10 line0");
    line_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    line_ready = 1'b0;
    wr(5'h0C, 32'h4004);
    chk("R10 line_valid", 64'(line_valid), 64'd0);
    rd(5'h0C, d); chk("R10 busy", 64'(d), 64'h5440_0004);
    chk("R10 irq", 64'(irq), 64'd0);
    rd(5'h10, d); chk("R10 progress", 64'(d), 64'd1);
    pulse_done();
    rd(5'h10, d); chk("R12 late done", 64'(d), 64'd1);
  endtask

  task automatic t_powerdown();
    logic [31:0] d;
    wr(5'h0C, 32'h0020_0004);
    wr(5'h0C, 32'h0020_0005);
    rd(5'h0C, d); chk("R11 blocked", 64'(d), 64'h5460_0004);
    chk("R11 no line", 64'(line_valid), 64'd0);
    wr(5'h0C, 32'h4);
    wr(5'h0C, 32'h5);
    chk("R11 restart", 64'(line_valid), 64'd1);
    wr(5'h0C, 32'h4000);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    line_ready = 1'b0; line_done = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_fields();
    t_frame();
    t_irq_clear();
    t_idle_pulses();
    t_busy_go();
    t_abort();
    t_powerdown();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule